// File: doc/BRIEF.md
# Eight-Bit Timer with Two Compare Channels

This block is an 8-bit timer/counter with two output compare channels, A and B. A small register file lets a host read and write the count, both compare values, the control fields, the interrupt enables and the event flags. A 3-bit clock select takes the counting tick from a free-running prescaler on the system clock. Three counting modes are provided: free-running, clear-on-compare-A, and fast PWM.

Each channel compares the count with its compare register on every cycle. On the next tick it sets its flag and drives its waveform output according to a 2-bit output-mode field. The block raises three interrupt requests: overflow, channel A and channel B. Each request is the AND of a flag and its enable. A flag is cleared by an acknowledge pulse or by the host writing a one to it. A force strobe applies a channel's match action to its output without a real match. All logic runs on one clock with a synchronous active-high reset.

Top module: `dual_cmp_timer`

## Requirements
- R1: With clock select (address 1, bits [2:0]) equal to 0, 6 or 7, the count never changes unless the host writes it.
- R2: Clock select values 1, 2, 3, 4 and 5 advance the count once every 1, 8, 64, 256 and 1024 system clocks.
- R3: The count (address 2) can be read and written at any time. A host write is visible after the write edge and overrides a clear or increment on that edge.
- R4: Wave mode is {address 1 bit 3, address 0 bits [1:0]}. Values 0, 1, 4, 5, 6 and 7 count freely: 0xFF wraps to 0x00 and sets the overflow flag (flag bit 0).
- R5: Wave mode 2 clears the count to 0 on the tick after it equals compare A (address 3). The overflow flag is set only on a wrap from 0xFF.
- R6: The interrupt request bits are {B, A, overflow}. Each is high while its flag (address 6) and its enable (address 5) are both set, using the same bit positions [2:0].
- R7: The tick that finds the count equal to a compare value (address 3 for A, address 4 for B) sets that channel's flag (bit 1 for A, bit 2 for B). The cycle in which the count first equals the compare value does not set the flag.
- R8: A flag clears on its irq_ack bit or when the host writes a one to it. Writing a zero leaves the flag unchanged.
- R9: Outside fast PWM, output mode 1 toggles, mode 2 clears and mode 3 sets the channel output on each match tick. The output mode for A is address 0 bits [7:6] and for B is bits [5:4].
- R10: In wave mode 3 (fast PWM), the top value is 0xFF and overflow is flagged there. Output mode 2 sets the output at bottom and clears it on a match, so it is high for C+1 of every 256 ticks, where C is the compare value. Output mode 3 inverts this. When C is 0xFF, the bottom action wins.
- R11: Output mode 0 drives the output low in every wave mode. Output mode 1 also drives it low in fast PWM.
- R12: Writing address 1 with bit 7 (A) or bit 6 (B) set applies that channel's match action at once. It sets no flag and does not change the count. These bits read back as 0.
- R13: After reset, every register reads 0, both outputs are low and no interrupt is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq_ack | input | 3 | Acknowledge pulses {B, A, overflow} |
| irq_req | output | 3 | Interrupt requests {B, A, overflow} |
| wave_a | output | 1 | Channel A waveform output |
| wave_b | output | 1 | Channel B waveform output |

## Verification
The bench runs every clock-select value and measures the interval between count changes. The exact interval separates the five dividers from one another and from the three stopped codes. It also runs every wave-mode code through a 0xFF wrap, which shows whether the reserved codes behave like free-running mode and the overflow flag rises exactly at the wrap. Clear-on-compare runs use compare values from 0 to 0xFF and show where the count folds back and when overflow is withheld. A fast-PWM sweep over spread compare values checks the high-time arithmetic on both channels at once. Channel A is non-inverting and channel B inverting, so the two high times must add to 256. This sweep covers the 0 and 0xFF extremes, where the bottom and match actions collide.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W  = 8;
    localparam int PRE_W  = 10;
    localparam int NCHAN  = 2;
    localparam int NFLAG  = NCHAN + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // register addresses
    localparam logic [2:0] ADR_CTRL_A = 3'd0;
    localparam logic [2:0] ADR_CTRL_B = 3'd1;
    localparam logic [2:0] ADR_COUNT  = 3'd2;
    localparam logic [2:0] ADR_CMP_A  = 3'd3;
    localparam logic [2:0] ADR_CMP_B  = 3'd4;
    localparam logic [2:0] ADR_IEN    = 3'd5;
    localparam logic [2:0] ADR_FLAGS  = 3'd6;

    typedef enum logic [1:0] {
        CM_FREE    = 2'd0,
        CM_CLR_CMP = 2'd1,
        CM_FASTPWM = 2'd2
    } cnt_mode_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'd0,
        OM_TOGGLE = 2'd1,
        OM_CLEAR  = 2'd2,
        OM_SET    = 2'd3
    } out_mode_e;

    typedef struct packed {
        logic [1:0] om_a;
        logic [1:0] om_b;
        logic [2:0] wave;
        logic [2:0] clk_sel;
    } ctrl_t;

    function automatic cnt_mode_e decode_mode(input logic [2:0] w);
        case (w)
            3'd2:    return CM_CLR_CMP;
            3'd3:    return CM_FASTPWM;
            default: return CM_FREE;
        endcase
    endfunction

    function automatic logic sel_active(input logic [2:0] cs);
        return (cs >= 3'd1) && (cs <= 3'd5);
    endfunction

    // low prescaler bits that must all be ones for a tick
    function automatic logic [PRE_W-1:0] sel_mask(input logic [2:0] cs);
        case (cs)
            3'd2:    return PRE_W'((1 << 3) - 1);
            3'd3:    return PRE_W'((1 << 6) - 1);
            3'd4:    return PRE_W'((1 << 8) - 1);
            3'd5:    return PRE_W'((1 << 10) - 1);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] clk_sel,
    output logic       tick
);
    logic [PW-1:0] pre_q;
    logic [PW-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    always_comb begin
        mask = PW'(sel_mask(clk_sel));
        tick = sel_active(clk_sel) && ((pre_q & mask) == mask);
    end

    // any divider above one leaves a gap after each tick
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && clk_sel >= 3'd2 && clk_sel <= 3'd5)
        |=> (!tick || clk_sel == 3'd1)); // R2

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  cnt_mode_e    mode,
    input  logic [W-1:0] cmp_a,
    input  logic         host_wr,
    input  logic [W-1:0] host_data,
    output logic [W-1:0] cnt,
    output logic         ovf_evt,
    output logic         bottom_evt
);
    localparam logic [W-1:0] TOP_FIXED = '1;

    logic         at_top;
    logic [W-1:0] cnt_d;

    always_comb begin
        at_top     = (mode == CM_CLR_CMP) ? (cnt == cmp_a) : (cnt == TOP_FIXED);
        bottom_evt = tick && at_top;
        ovf_evt    = tick && (cnt == TOP_FIXED);
        if (host_wr)         cnt_d = host_data;
        else if (bottom_evt) cnt_d = '0;
        else if (tick)       cnt_d = cnt + 1'b1;
        else                 cnt_d = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_d;
    end

    AST_HOST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> (cnt == $past(host_data))); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!tick && !host_wr) |=> $stable(cnt)); // R1

    AST_CLR_CMP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (mode == CM_CLR_CMP && tick && cnt == cmp_a && !host_wr) |=> (cnt == '0)); // R5

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
    import tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  cnt_mode_e    mode,
    input  out_mode_e    om,
    input  logic         force_now,
    input  logic         bottom,
    output logic         hit,
    output logic         wave
);
    logic pwm;
    logic act;
    logic oc_q;
    logic oc_d;

    always_comb begin
        pwm  = (mode == CM_FASTPWM);
        hit  = tick && (cnt == cmp);
        act  = hit || force_now;
        oc_d = oc_q;
        if (pwm) begin
            // bottom action wins over a match on the same tick
            case (om)
                OM_CLEAR: if (bottom) oc_d = 1'b1; else if (act) oc_d = 1'b0;
                OM_SET:   if (bottom) oc_d = 1'b0; else if (act) oc_d = 1'b1;
                default:  oc_d = oc_q;
            endcase
        end else if (act) begin
            case (om)
                OM_TOGGLE: oc_d = !oc_q;
                OM_CLEAR:  oc_d = 1'b0;
                OM_SET:    oc_d = 1'b1;
                default:   oc_d = oc_q;
            endcase
        end
        wave = (om == OM_OFF || (pwm && om == OM_TOGGLE)) ? 1'b0 : oc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) oc_q <= 1'b0;
        else     oc_q <= oc_d;
    end

    AST_PWM_BOTTOM_SET: assert property (@(posedge clk) disable iff (rst)
        (pwm && om == OM_CLEAR && bottom)
        |=> (wave || om != OM_CLEAR || mode != CM_FASTPWM)); // R10

    AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        (!pwm && om == OM_SET && act)
        |=> (wave || om != OM_SET)); // R9

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic [2:0] irq_ack,
    output logic [2:0] irq_req,
    output logic       wave_a,
    output logic       wave_b
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cmp_q  [NCHAN];
    logic [NFLAG-1:0] ien_q;
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] flag_clr;
    logic [NFLAG-1:0] flag_set;

    logic             tick;
    cnt_mode_e        mode;
    logic [CNT_W-1:0] cnt;
    logic             ovf_evt;
    logic             bottom_evt;
    logic             wr_cnt;
    logic             wr_ctrl_b;
    out_mode_e        om     [NCHAN];
    logic             force_s[NCHAN];
    logic             hit    [NCHAN];
    logic             wave   [NCHAN];

    always_comb begin
        mode       = decode_mode(ctrl_q.wave);
        wr_cnt     = reg_wr && (reg_addr == ADR_COUNT);
        wr_ctrl_b  = reg_wr && (reg_addr == ADR_CTRL_B);
        om[0]      = out_mode_e'(ctrl_q.om_a);
        om[1]      = out_mode_e'(ctrl_q.om_b);
        force_s[0] = wr_ctrl_b && reg_wdata[7];
        force_s[1] = wr_ctrl_b && reg_wdata[6];
    end

    // host register file
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            cmp_q[0] <= '0;
            cmp_q[1] <= '0;
            ien_q    <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADR_CTRL_A: begin
                    ctrl_q.om_a      <= reg_wdata[7:6];
                    ctrl_q.om_b      <= reg_wdata[5:4];
                    ctrl_q.wave[1:0] <= reg_wdata[1:0];
                end
                ADR_CTRL_B: begin
                    ctrl_q.wave[2] <= reg_wdata[3];
                    ctrl_q.clk_sel <= reg_wdata[2:0];
                end
                ADR_CMP_A: cmp_q[0] <= reg_wdata;
                ADR_CMP_B: cmp_q[1] <= reg_wdata;
                ADR_IEN:   ien_q    <= reg_wdata[NFLAG-1:0];
                default: ;
            endcase
        end
    end

    tmr_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .clk_sel (ctrl_q.clk_sel),
        .tick    (tick)
    );

    tmr_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .mode       (mode),
        .cmp_a      (cmp_q[0]),
        .host_wr    (wr_cnt),
        .host_data  (reg_wdata),
        .cnt        (cnt),
        .ovf_evt    (ovf_evt),
        .bottom_evt (bottom_evt)
    );

    for (genvar i = 0; i < NCHAN; i++) begin : g_chan
        tmr_cmp_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick),
            .cnt       (cnt),
            .cmp       (cmp_q[i]),
            .mode      (mode),
            .om        (om[i]),
            .force_now (force_s[i]),
            .bottom    (bottom_evt),
            .hit       (hit[i]),
            .wave      (wave[i])
        );
    end

    // flags: a set event wins over a clear in the same cycle
    always_comb begin
        flag_set = {hit[1], hit[0], ovf_evt};
        flag_clr = irq_ack;
        if (reg_wr && reg_addr == ADR_FLAGS)
            flag_clr = flag_clr | reg_wdata[NFLAG-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (flag_q & ~flag_clr) | flag_set;
    end

    always_comb begin
        irq_req = flag_q & ien_q;
        wave_a  = wave[0];
        wave_b  = wave[1];
        case (reg_addr)
            ADR_CTRL_A: reg_rdata = {ctrl_q.om_a, ctrl_q.om_b, 2'b00, ctrl_q.wave[1:0]};
            ADR_CTRL_B: reg_rdata = {4'b0000, ctrl_q.wave[2], ctrl_q.clk_sel};
            ADR_COUNT:  reg_rdata = cnt;
            ADR_CMP_A:  reg_rdata = cmp_q[0];
            ADR_CMP_B:  reg_rdata = cmp_q[1];
            ADR_IEN:    reg_rdata = {{(8-NFLAG){1'b0}}, ien_q};
            ADR_FLAGS:  reg_rdata = {{(8-NFLAG){1'b0}}, flag_q};
            default:    reg_rdata = '0;
        endcase
    end

    AST_FLAG_A_LATE: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q[1]) |-> $past(tick && cnt == cmp_q[0])); // R7

    AST_FLAG_B_LATE: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q[2]) |-> $past(tick && cnt == cmp_q[1])); // R7

    AST_WRITE_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADR_FLAGS && !reg_wdata[2] && !irq_ack[2] && flag_q[2])
        |=> flag_q[2]); // R8

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (irq_ack[0] && !ovf_evt) |=> !flag_q[0]); // R8

endmodule

// File: tb/tb_dual_cmp_timer.sv
`timescale 1ns/1ps
module tb_dual_cmp_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [2:0] irq_ack = '0;
    logic [2:0] irq_req;
    logic       wave_a;
    logic       wave_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dual_cmp_timer dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
        .irq_req(irq_req), .wave_a(wave_a), .wave_b(wave_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.2;
        d = reg_rdata;
    endtask

    task automatic ack(input logic [2:0] v);
        @(negedge clk);
        irq_ack = v;
        @(negedge clk);
        irq_ack = '0;
    endtask

    // cycles until the count next changes
    task automatic wait_change(output int cyc);
        logic [7:0] prev, cur;
        rd(3'd2, prev);
        cyc = 0;
        do begin
            step();
            cyc++;
            rd(3'd2, cur);
        end while (cur == prev && cyc < 3000);
    endtask

    initial begin
        logic [7:0] d;
        int cyc, errs;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R13 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R13 register reset", d, 0);
        end
        chk("R13 outputs low", {irq_req, wave_a, wave_b}, 0);

        // R2 divider sweep
        for (int cs = 1; cs <= 5; cs++) begin
            int expd;
            expd = (cs == 1) ? 1 : (cs == 2) ? 8 : (cs == 3) ? 64 : (cs == 4) ? 256 : 1024;
            wr(3'd1, 8'(cs));
            wait_change(cyc);
            wait_change(cyc);
            chk("R2 tick interval", cyc, expd);
        end

        // R1 stopped codes
        for (int k = 0; k < 3; k++) begin
            logic [2:0] cs;
            cs = (k == 0) ? 3'd0 : (k == 1) ? 3'd6 : 3'd7;
            wr(3'd1, {5'd0, cs});
            wr(3'd2, 8'h55);
            repeat (1100) step();
            rd(3'd2, d);
            chk("R1 count holds when stopped", d, 8'h55);
        end

        // R3 host write wins over a tick
        wr(3'd1, 8'd1);
        wr(3'd2, 8'h40);
        rd(3'd2, d);
        chk("R3 written value visible", d, 8'h40);
        step();
        rd(3'd2, d);
        chk("R3 counting resumes", d, 8'h41);

        // R4 wrap and overflow for every free-running wave code
        for (int w = 0; w < 8; w++) begin
            if (w == 2 || w == 3) continue;
            wr(3'd1, 8'((w >> 2) << 3));
            wr(3'd0, 8'(w & 3));
            wr(3'd2, 8'hFD);
            wr(3'd6, 8'h07);
            wr(3'd1, 8'(((w >> 2) << 3) | 1));
            step(); step();
            rd(3'd2, d); chk("R4 count at FF", d, 8'hFF);
            rd(3'd6, d); chk("R4 no overflow before wrap", d & 1, 0);
            step();
            rd(3'd2, d); chk("R4 wrap to 0", d, 0);
            rd(3'd6, d); chk("R4 overflow at wrap", d & 1, 1);
        end

        // R5 clear on compare A
        wr(3'd1, 8'd0);
        wr(3'd0, 8'd2);
        for (int k = 0; k < 6; k++) begin
            int c, mx;
            c = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 3 : (k == 3) ? 10 : (k == 4) ? 8'h80 : 8'hFE;
            wr(3'd3, 8'(c));
            wr(3'd2, 8'd0);
            wr(3'd6, 8'h07);
            wr(3'd1, 8'd1);
            mx = 0;
            for (int t = 0; t < 3 * (c + 1) + 3; t++) begin
                step();
                rd(3'd2, d);
                if (d > mx) mx = d;
            end
            chk("R5 count peaks at compare A", mx, c);
            rd(3'd6, d);
            chk("R5 no overflow below FF", d & 1, 0);
            wr(3'd1, 8'd0);
        end
        wr(3'd3, 8'hFF);
        wr(3'd2, 8'hFE);
        wr(3'd6, 8'h07);
        wr(3'd1, 8'd1);
        step();
        rd(3'd6, d); chk("R5 no overflow at FF yet", d & 1, 0);
        step();
        rd(3'd2, d); chk("R5 wrap from FF", d, 0);
        rd(3'd6, d); chk("R5 overflow on FF wrap", d & 1, 1);

        // R7 compare flag one tick late
        wr(3'd1, 8'd0);
        wr(3'd0, 8'd0);
        wr(3'd4, 8'h10);
        wr(3'd2, 8'h0E);
        wr(3'd6, 8'h07);
        wr(3'd1, 8'd1);
        step();
        rd(3'd2, d); chk("R7 count 0F", d, 8'h0F);
        step();
        rd(3'd2, d); chk("R7 count equals compare", d, 8'h10);
        rd(3'd6, d); chk("R7 flag not yet set", (d >> 2) & 1, 0);
        step();
        rd(3'd6, d); chk("R7 flag set on next tick", (d >> 2) & 1, 1);
        wr(3'd1, 8'd0);
        wr(3'd6, 8'h03);

        // R6 request gating
        chk("R6 no request without enable", irq_req, 0);
        wr(3'd5, 8'h04);
        chk("R6 request B", irq_req, 4);
        wr(3'd5, 8'h07);
        chk("R6 only flagged source requests", irq_req, 4);

        // R8 clearing
        wr(3'd6, 8'h00);
        rd(3'd6, d); chk("R8 write zero keeps flag", (d >> 2) & 1, 1);
        ack(3'b100);
        rd(3'd6, d); chk("R8 acknowledge clears", (d >> 2) & 1, 0);
        chk("R6 request drops with flag", irq_req, 0);
        wr(3'd2, 8'h0F);
        wr(3'd1, 8'd1);
        repeat (3) step();
        wr(3'd1, 8'd0);
        rd(3'd6, d); chk("R8 flag set again", (d >> 2) & 1, 1);
        wr(3'd6, 8'h04);
        rd(3'd6, d); chk("R8 write one clears", (d >> 2) & 1, 0);
        wr(3'd5, 8'h00);

        // R9 non-PWM output actions in clear-on-compare
        wr(3'd3, 8'd4);
        wr(3'd4, 8'd2);
        wr(3'd0, 8'h52);
        wr(3'd2, 8'd0);
        wr(3'd1, 8'd1);
        begin
            int ta, tb;
            logic pa, pb;
            ta = 0; tb = 0; pa = wave_a; pb = wave_b;
            for (int t = 0; t < 50; t++) begin
                step();
                if (wave_a != pa) ta++;
                if (wave_b != pb) tb++;
                pa = wave_a; pb = wave_b;
            end
            chk("R9 toggle A every 5 ticks", ta, 10);
            chk("R9 toggle B every 5 ticks", tb, 10);
        end
        wr(3'd0, 8'hE2);
        repeat (12) step();
        chk("R9 set mode A high", wave_a, 1);
        chk("R9 clear mode B low", wave_b, 0);
        wr(3'd0, 8'hB2);
        repeat (12) step();
        chk("R9 clear mode A low", wave_a, 0);
        chk("R9 set mode B high", wave_b, 1);

        // R10 fast PWM overflow at top
        wr(3'd1, 8'd0);
        wr(3'd0, 8'hB3);
        wr(3'd2, 8'hFE);
        wr(3'd6, 8'h07);
        wr(3'd1, 8'd1);
        step();
        rd(3'd6, d); chk("R10 no overflow before top", d & 1, 0);
        step();
        rd(3'd6, d); chk("R10 overflow at top", d & 1, 1);

        // R10 duty sweep: A non-inverting, B inverting
        for (int k = 0; k < 19; k++) begin
            int c, ha, hb, ea;
            c = (k < 16) ? k * 17 : (k == 16) ? 1 : (k == 17) ? 254 : 128;
            wr(3'd3, 8'(c));
            wr(3'd4, 8'(c));
            repeat (260) step();
            ha = 0; hb = 0;
            for (int t = 0; t < 256; t++) begin
                step();
                ha += wave_a;
                hb += wave_b;
            end
            ea = (c == 255) ? 256 : c + 1;
            chk("R10 non-inverting high time", ha, ea);
            chk("R10 inverting high time", hb, 256 - ea);
        end

        // R11 disconnected and PWM toggle code
        wr(3'd0, 8'h13);
        errs = 0;
        for (int t = 0; t < 300; t++) begin
            step();
            if (wave_a || wave_b) errs++;
        end
        chk("R11 outputs low in PWM with codes 0 and 1", errs, 0);
        wr(3'd0, 8'h00);
        errs = 0;
        for (int t = 0; t < 300; t++) begin
            step();
            if (wave_a || wave_b) errs++;
        end
        chk("R11 outputs low with code 0", errs, 0);

        // R12 force strobes
        wr(3'd1, 8'd0);
        wr(3'd0, 8'h40);
        wr(3'd2, 8'h33);
        wr(3'd6, 8'h07);
        begin
            logic w0;
            w0 = wave_a;
            wr(3'd1, 8'h80);
            chk("R12 force toggles A", wave_a, !w0);
        end
        rd(3'd6, d); chk("R12 force sets no flag", d, 0);
        rd(3'd2, d); chk("R12 force leaves count", d, 8'h33);
        rd(3'd1, d); chk("R12 force bits read 0", d, 0);
        wr(3'd0, 8'hC0);
        wr(3'd1, 8'h80);
        chk("R12 force set A", wave_a, 1);
        wr(3'd0, 8'h80);
        wr(3'd1, 8'h80);
        chk("R12 force clear A", wave_a, 0);
        wr(3'd0, 8'h30);
        wr(3'd1, 8'h40);
        chk("R12 force set B", wave_b, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule